// File: doc/BRIEF.md
# Burst ADC Conversion Sequencer

This block drives a successive-approximation converter through its power-up, tracking and conversion phases. It runs on a fast burst clock of its own, so a whole group of conversions can finish while a slow system clock advances by a single cycle, or while it is stopped. A convert-start request from the system clock domain launches a sequence of 1, 4, 8, 16, 32 or 64 conversions. The results of the sequence are summed into a 16-bit accumulator. The end-of-conversion flag is raised only when the last conversion of the sequence has been added. The window comparison on the sum is also made only at that point.

In burst mode a single request runs every conversion of the sequence back to back. With burst mode off, each request runs one conversion, and the sequence completes after the programmed number of requests. A configuration bit selects the idle state between sequences. When it is clear, the converter is unpowered while idle, and every start first spends a programmable power-up time in tracking. An option bit adds three more tracking cycles before each conversion. Starts that arrive too soon after an accepted one are dropped in the system domain. A start that reaches the sequencer while a sequence is running is dropped and recorded in a sticky overrun flag.

Top module: `burst_adc_seq`

## Requirements
- R1: In burst mode one accepted start produces exactly N conversion pulses. The repeat code rpt_sel maps 0→1, 1→4, 2→8, 3→16, 4→32, 5→64, and 6 or 7→64.
- R2: After a sequence completes, acc equals the sum of the adc_data values taken in that sequence. acc is cleared when a new sequence starts and never wraps.
- R3: With burst mode off, each accepted start produces exactly one conversion, and N accepted starts form one sequence.
- R4: eoc_flag (system domain) rises only after the N-th conversion of a sequence. It stays high until eoc_clr is asserted.
- R5: On completion, win_flag is set when win_lo ≤ acc ≤ win_hi, with both limits inclusive. Partial sums never set it. It stays set until win_clr is asserted.
- R6: With keep_pwr=0, adc_pwr is low while idle. A start then holds adc_trk high for pwrup_cyc+1 burst cycles of power-up, followed by trk_cyc+1 cycles of tracking, before the first adc_cnv. With keep_pwr=1, adc_pwr stays high and tracking alone (trk_cyc+1 cycles) precedes the conversion. adc_cnv occurs only while powered and directly after tracking.
- R7: With xtrk=1, exactly 3 further burst cycles of tracking are inserted before every conversion of the sequence.
- R8: In the system domain, a start_req is accepted at most once per 4 system clock cycles. Requests in the 3 cycles after an accepted one are ignored and do not set the overrun flag.
- R9: A start that reaches the sequencer while a sequence is running is ignored and sets ovr_flag. ovr_flag stays set until ovr_clr is asserted.
- R10: After reset, acc, eoc_flag, win_flag, ovr_flag, adc_trk and adc_cnv are all 0, and adc_pwr equals keep_pwr.
- R11: adc_cnv is a one-burst-cycle pulse. The sequencer then waits for adc_done and adds adc_data on that cycle, with exactly one result taken per pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock; may be slow |
| clk_b | input | 1 | Burst clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| start_req | input | 1 | Convert-start request, system domain |
| burst_en | input | 1 | 1: one start runs the whole sequence |
| keep_pwr | input | 1 | 1: converter stays powered while idle |
| rpt_sel | input | 3 | Repeat count code |
| pwrup_cyc | input | 8 | Power-up time minus one, burst cycles |
| trk_cyc | input | 4 | Tracking time minus one, burst cycles |
| xtrk | input | 1 | Adds 3 tracking cycles before each conversion |
| win_lo | input | 16 | Window lower limit |
| win_hi | input | 16 | Window upper limit |
| eoc_clr | input | 1 | Clears eoc_flag, system domain |
| win_clr | input | 1 | Clears win_flag, burst domain |
| ovr_clr | input | 1 | Clears ovr_flag, burst domain |
| adc_pwr | output | 1 | Converter power enable |
| adc_trk | output | 1 | Converter tracking |
| adc_cnv | output | 1 | Conversion start pulse |
| adc_done | input | 1 | Conversion finished, data valid |
| adc_data | input | 10 | Conversion result |
| acc | output | 16 | Accumulated result |
| eoc_flag | output | 1 | Sequence complete, system domain, sticky |
| win_flag | output | 1 | Window hit, sticky |
| ovr_flag | output | 1 | Start overrun, sticky |

## Verification
The hardest case to reach is an overrun. It needs a request that crosses into the burst domain while a sequence is still running, yet that request must not be dropped earlier by the system-side rate limit. The stimulus runs a 64-conversion burst with extra tracking enabled. It sends a second request eight system cycles after the first, which is past the rate-limit window but well inside the burst. The bench then checks three things: exactly 64 conversions took place, the sum belongs to that burst alone, and the overrun flag stays set until it is cleared. A non-burst sequence with a window that already contains the first partial sum shows that the window flag waits for the final result.

// File: rtl/burst_adc_seq.sv
`timescale 1ns/1ps
module burst_adc_seq #(
  parameter int DW       = 10,
  parameter int AW       = 16,
  parameter int PW       = 8,
  parameter int TW       = 4,
  parameter int XTRK_CYC = 3,
  parameter int MAX_RPT  = 64
) (
  input  logic          clk_sys,
  input  logic          clk_b,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic          burst_en,
  input  logic          keep_pwr,
  input  logic [2:0]    rpt_sel,
  input  logic [PW-1:0] pwrup_cyc,
  input  logic [TW-1:0] trk_cyc,
  input  logic          xtrk,
  input  logic [AW-1:0] win_lo,
  input  logic [AW-1:0] win_hi,
  input  logic          eoc_clr,
  input  logic          win_clr,
  input  logic          ovr_clr,
  output logic          adc_pwr,
  output logic          adc_trk,
  output logic          adc_cnv,
  input  logic          adc_done,
  input  logic [DW-1:0] adc_data,
  output logic [AW-1:0] acc,
  output logic          eoc_flag,
  output logic          win_flag,
  output logic          ovr_flag
);
  localparam int CW  = $clog2(MAX_RPT) + 1;
  localparam int TMW = (PW > TW) ? PW : TW;

  typedef enum logic [2:0] {S_IDLE, S_PWR, S_TRK, S_XTRK, S_CNV, S_WAIT} st_t;

  st_t            st;
  logic [TMW-1:0] tmr;
  logic [CW-1:0]  cnt, n_tgt;
  logic [1:0]     gap;
  logic           req_tog, eoc_tog;
  logic [2:0]     rq_s, eo_s;

  // system domain: rate limit, request toggle, completion flag
  always_ff @(posedge clk_sys or negedge rst_n)
    if (!rst_n) begin
      gap <= '0; req_tog <= 1'b0; eo_s <= '0; eoc_flag <= 1'b0;
    end else begin
      eo_s <= {eo_s[1:0], eoc_tog};
      if (start_req && gap == 2'd0) begin
        req_tog <= ~req_tog;
        gap     <= 2'd3;
      end else if (gap != 2'd0) gap <= gap - 2'd1;
      if (eo_s[2] ^ eo_s[1]) eoc_flag <= 1'b1;
      else if (eoc_clr)      eoc_flag <= 1'b0;
    end

  always_ff @(posedge clk_b or negedge rst_n)
    if (!rst_n) rq_s <= '0;
    else        rq_s <= {rq_s[1:0], req_tog};

  wire start_b = rq_s[2] ^ rq_s[1];

  always_comb
    case (rpt_sel)
      3'd0:    n_tgt = CW'(1);
      3'd1:    n_tgt = CW'(4);
      3'd2:    n_tgt = CW'(8);
      3'd3:    n_tgt = CW'(16);
      3'd4:    n_tgt = CW'(32);
      default: n_tgt = CW'(MAX_RPT);
    endcase

  wire [AW-1:0] sum_nx  = acc + AW'(adc_data);
  wire          last    = (cnt + CW'(1)) == n_tgt;
  wire          win_hit = (sum_nx >= win_lo) && (sum_nx <= win_hi);

  assign adc_pwr = keep_pwr || (st != S_IDLE);
  assign adc_trk = (st == S_PWR) || (st == S_TRK) || (st == S_XTRK);
  assign adc_cnv = (st == S_CNV);

  always_ff @(posedge clk_b or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; tmr <= '0; cnt <= '0; acc <= '0;
      eoc_tog <= 1'b0; win_flag <= 1'b0; ovr_flag <= 1'b0;
    end else begin
      if (win_clr) win_flag <= 1'b0;
      if (ovr_clr) ovr_flag <= 1'b0;
      if (start_b && st != S_IDLE) ovr_flag <= 1'b1;
      case (st)
        S_IDLE:
          if (start_b) begin
            if (cnt == '0) acc <= '0;
            if (keep_pwr) begin st <= S_TRK; tmr <= TMW'(trk_cyc); end
            else          begin st <= S_PWR; tmr <= TMW'(pwrup_cyc); end
          end
        S_PWR:
          if (tmr == '0) begin st <= S_TRK; tmr <= TMW'(trk_cyc); end
          else tmr <= tmr - TMW'(1);
        S_TRK:
          if (tmr == '0) begin
            if (xtrk) begin st <= S_XTRK; tmr <= TMW'(XTRK_CYC - 1); end
            else st <= S_CNV;
          end else tmr <= tmr - TMW'(1);
        S_XTRK:
          if (tmr == '0) st <= S_CNV;
          else tmr <= tmr - TMW'(1);
        S_CNV: st <= S_WAIT;
        S_WAIT:
          if (adc_done) begin
            acc <= sum_nx;
            if (last) begin
              cnt     <= '0;
              eoc_tog <= ~eoc_tog;
              if (win_hit) win_flag <= 1'b1;
              st <= S_IDLE;
            end else begin
              cnt <= cnt + CW'(1);
              if (burst_en) begin st <= S_TRK; tmr <= TMW'(trk_cyc); end
              else st <= S_IDLE;
            end
          end
        default: st <= S_IDLE;
      endcase
    end
endmodule

// File: rtl/burst_adc_seq_chk.sv
`timescale 1ns/1ps
module burst_adc_seq_chk #(parameter int AW = 16) (
  input logic          clk_b,
  input logic          rst_n,
  input logic          adc_pwr,
  input logic          adc_trk,
  input logic          adc_cnv,
  input logic          xtrk,
  input logic [AW-1:0] acc,
  input logic          win_flag,
  input logic          win_clr,
  input logic          ovr_flag,
  input logic          ovr_clr
);
  p_cnv_after_trk_r6: assert property (@(posedge clk_b) disable iff (!rst_n)
    adc_cnv |-> $past(adc_trk));
  p_pwr_active_r6: assert property (@(posedge clk_b) disable iff (!rst_n)
    (adc_trk || adc_cnv) |-> adc_pwr);
  p_xtrk_r7: assert property (@(posedge clk_b) disable iff (!rst_n)
    (adc_cnv && xtrk) |-> ($past(adc_trk, 1) && $past(adc_trk, 2) && $past(adc_trk, 3)));
  p_cnv_pulse_r11: assert property (@(posedge clk_b) disable iff (!rst_n)
    adc_cnv |=> !adc_cnv);
  p_no_overflow_r2: assert property (@(posedge clk_b) disable iff (!rst_n)
    (acc != $past(acc)) |-> ((acc > $past(acc)) || (acc == '0)));
  p_win_sticky_r5: assert property (@(posedge clk_b) disable iff (!rst_n)
    (win_flag && !win_clr) |=> win_flag);
  p_ovr_sticky_r9: assert property (@(posedge clk_b) disable iff (!rst_n)
    (ovr_flag && !ovr_clr) |=> ovr_flag);
endmodule

bind burst_adc_seq burst_adc_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_burst_adc_seq.sv
`timescale 1ns/1ps
module tb_burst_adc_seq;
  typedef struct packed {
    logic b; logic k; logic [2:0] r; logic [7:0] p; logic [3:0] t; logic x;
    logic [15:0] lo; logic [15:0] hi;
  } vec_t;

  localparam vec_t VT [8] = '{
    '{1'b1, 1'b0, 3'd1, 8'd5, 4'd2, 1'b0, 16'h0000, 16'hFFFF},
    '{1'b1, 1'b1, 3'd0, 8'd7, 4'd0, 1'b1, 16'hFFFF, 16'hFFFF},
    '{1'b1, 1'b0, 3'd5, 8'd3, 4'd1, 1'b1, 16'h0000, 16'hFFFF},
    '{1'b0, 1'b1, 3'd1, 8'd0, 4'd3, 1'b0, 16'h0000, 16'h0000},
    '{1'b0, 1'b0, 3'd2, 8'd2, 4'd1, 1'b1, 16'h0000, 16'hFFFF},
    '{1'b1, 1'b1, 3'd3, 8'd0, 4'd4, 1'b0, 16'h0000, 16'h000A},
    '{1'b1, 1'b0, 3'd4, 8'd9, 4'd0, 1'b0, 16'h0000, 16'hFFFF},
    '{1'b1, 1'b1, 3'd7, 8'd0, 4'd1, 1'b0, 16'h0000, 16'hFFFF}
  };

  logic clk_sys = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
  logic start_req = 1'b0, burst_en = 1'b0, keep_pwr = 1'b0, xtrk = 1'b0;
  logic [2:0] rpt_sel = '0;
  logic [7:0] pwrup_cyc = '0;
  logic [3:0] trk_cyc = '0;
  logic [15:0] win_lo = '0, win_hi = '0;
  logic eoc_clr = 1'b0, win_clr = 1'b0, ovr_clr = 1'b0;
  logic adc_pwr, adc_trk, adc_cnv;
  logic adc_done = 1'b0;
  logic [9:0] adc_data = '0;
  logic [15:0] acc;
  logic eoc_flag, win_flag, ovr_flag;

  int total = 0, bad = 0;
  int n_cnv = 0, n_done = 0, run = 0, dly = 0;
  int runs [4096];

  always #2  clk_b   = ~clk_b;
  always #20 clk_sys = ~clk_sys;

  burst_adc_seq dut (.*);

  function automatic int smp(input int i);
    return (i * 37 + 113) % 1024;
  endfunction

  function automatic int sum_of(input int b, input int n);
    int s = 0;
    for (int i = 0; i < n; i++) s += smp(b + i);
    return s;
  endfunction

  function automatic int nrep(input logic [2:0] r);
    case (r)
      3'd0: return 1; 3'd1: return 4; 3'd2: return 8;
      3'd3: return 16; 3'd4: return 32; default: return 64;
    endcase
  endfunction

  // converter model and monitor
  always @(negedge clk_b) begin
    if (adc_cnv) begin runs[n_cnv] = run; n_cnv++; end
    if (adc_trk) run++; else run = 0;
    adc_done = 1'b0;
    if (dly > 0) begin
      dly--;
      if (dly == 0) begin adc_done = 1'b1; adc_data = 10'(smp(n_done)); n_done++; end
    end
    if (adc_cnv) dly = 2;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk_sys) start_req = 1'b1;
    @(negedge clk_sys) start_req = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk_sys) eoc_clr = 1'b1;
    @(negedge clk_sys) eoc_clr = 1'b0;
    @(negedge clk_b) begin win_clr = 1'b1; ovr_clr = 1'b1; end
    @(negedge clk_b) begin win_clr = 1'b0; ovr_clr = 1'b0; end
  endtask

  task automatic wait_done(input int target);
    for (int i = 0; i < 5000; i++) begin
      if (n_done >= target) break;
      @(negedge clk_b);
    end
  endtask

  task automatic wait_eoc();
    for (int i = 0; i < 4000; i++) begin
      if (eoc_flag) break;
      @(negedge clk_sys);
    end
    chk(eoc_flag == 1'b1, "R4", "eoc raised", eoc_flag, 1);
  endtask

  task automatic run_vec(input vec_t v);
    int n, base, esum, f_run, l_run;
    bit ewin;
    @(negedge clk_sys);
    burst_en = v.b; keep_pwr = v.k; rpt_sel = v.r; pwrup_cyc = v.p;
    trk_cyc = v.t; xtrk = v.x; win_lo = v.lo; win_hi = v.hi;
    n = nrep(v.r);
    base = n_cnv;
    esum = sum_of(base, n);
    ewin = (esum >= int'(v.lo)) && (esum <= int'(v.hi));
    f_run = (v.k ? 0 : int'(v.p) + 1) + int'(v.t) + 1 + (v.x ? 3 : 0);
    l_run = (v.b && n > 1) ? int'(v.t) + 1 + (v.x ? 3 : 0) : f_run;
    repeat (4) @(negedge clk_sys);
    if (v.b) pulse_start();
    else begin
      for (int k = 0; k < n; k++) begin
        pulse_start();
        wait_done(base + k + 1);
        repeat (6) @(negedge clk_sys);
        chk(n_cnv - base == k + 1, "R3", "one conversion per start", n_cnv - base, k + 1);
        if (k < n - 1) begin
          chk(eoc_flag == 1'b0, "R4", "eoc before last", eoc_flag, 0);
          chk(win_flag == 1'b0, "R5", "window on partial sum", win_flag, 0);
        end
      end
    end
    wait_eoc();
    repeat (8) @(negedge clk_sys);
    chk(n_cnv - base == n, "R1", "conversions in sequence", n_cnv - base, n);
    chk(n_done == n_cnv, "R11", "one result per pulse", n_done, n_cnv);
    chk(int'(acc) == esum, "R2", "accumulated sum", acc, esum);
    chk(win_flag == ewin, "R5", "window flag", win_flag, ewin);
    chk(runs[base] == f_run, "R6", "first tracking length", runs[base], f_run);
    chk(runs[n_cnv - 1] == l_run, "R7", "last tracking length", runs[n_cnv - 1], l_run);
    chk(adc_pwr == v.k, "R6", "idle power", adc_pwr, v.k);
    chk(ovr_flag == 1'b0, "R9", "no overrun", ovr_flag, 0);
    clear_flags();
  endtask

  initial begin
    bit wd_hit = 1'b0;
    fork
      begin
        repeat (5) @(negedge clk_sys);
        rst_n = 1'b1;
        repeat (2) @(negedge clk_sys);
        // R10 reset state
        chk(acc == 16'd0, "R10", "acc", acc, 0);
        chk(eoc_flag == 1'b0, "R10", "eoc_flag", eoc_flag, 0);
        chk(win_flag == 1'b0, "R10", "win_flag", win_flag, 0);
        chk(ovr_flag == 1'b0, "R10", "ovr_flag", ovr_flag, 0);
        chk(adc_trk == 1'b0 && adc_cnv == 1'b0, "R10", "trk/cnv", {adc_trk, adc_cnv}, 0);
        chk(adc_pwr == 1'b0, "R10", "adc_pwr follows keep_pwr", adc_pwr, 0);

        for (int i = 0; i < 8; i++) run_vec(VT[i]);

        // R5 inclusive limits
        begin
          vec_t v;
          int s;
          s = sum_of(n_cnv, 4);
          v = '{1'b1, 1'b1, 3'd1, 8'd0, 4'd1, 1'b0, 16'(s), 16'(s)};
          run_vec(v);
          s = sum_of(n_cnv, 4);
          v = '{1'b1, 1'b1, 3'd1, 8'd0, 4'd1, 1'b0, 16'(s + 1), 16'hFFFF};
          run_vec(v);
          s = sum_of(n_cnv, 4);
          v = '{1'b1, 1'b0, 3'd1, 8'd1, 4'd1, 1'b0, 16'h0000, 16'(s)};
          run_vec(v);
        end

        // R8 rate limit in the system domain
        begin
          int base;
          @(negedge clk_sys);
          burst_en = 1'b0; keep_pwr = 1'b1; rpt_sel = 3'd0; trk_cyc = 4'd1; xtrk = 1'b0;
          win_lo = 16'h0; win_hi = 16'hFFFF;
          repeat (4) @(negedge clk_sys);
          base = n_cnv;
          @(negedge clk_sys) start_req = 1'b1;
          @(negedge clk_sys) start_req = 1'b0;
          @(negedge clk_sys) start_req = 1'b1;
          @(negedge clk_sys) start_req = 1'b0;
          repeat (20) @(negedge clk_sys);
          chk(n_cnv - base == 1, "R8", "early request dropped", n_cnv - base, 1);
          chk(ovr_flag == 1'b0, "R8", "drop sets no overrun", ovr_flag, 0);
          pulse_start();
          repeat (20) @(negedge clk_sys);
          chk(n_cnv - base == 2, "R8", "later request taken", n_cnv - base, 2);
          // R4 stickiness
          chk(eoc_flag == 1'b1, "R4", "eoc sticky", eoc_flag, 1);
          @(negedge clk_sys) eoc_clr = 1'b1;
          @(negedge clk_sys) eoc_clr = 1'b0;
          @(negedge clk_sys);
          chk(eoc_flag == 1'b0, "R4", "eoc cleared", eoc_flag, 0);
          clear_flags();
        end

        // R9 overrun during a long burst
        begin
          int base, esum;
          @(negedge clk_sys);
          burst_en = 1'b1; keep_pwr = 1'b1; rpt_sel = 3'd5; trk_cyc = 4'd2; xtrk = 1'b1;
          repeat (4) @(negedge clk_sys);
          base = n_cnv;
          esum = sum_of(base, 64);
          pulse_start();
          repeat (6) @(negedge clk_sys);
          pulse_start();
          wait_eoc();
          repeat (30) @(negedge clk_sys);
          chk(ovr_flag == 1'b1, "R9", "overrun set", ovr_flag, 1);
          chk(n_cnv - base == 64, "R9", "second start ignored", n_cnv - base, 64);
          chk(int'(acc) == esum, "R9", "sum unaffected", acc, esum);
          repeat (10) @(negedge clk_b);
          chk(ovr_flag == 1'b1, "R9", "overrun sticky", ovr_flag, 1);
          @(negedge clk_b) ovr_clr = 1'b1;
          @(negedge clk_b) ovr_clr = 1'b0;
          @(negedge clk_b);
          chk(ovr_flag == 1'b0, "R9", "overrun cleared", ovr_flag, 0);
          clear_flags();
        end
      end
      begin
        repeat (150000) @(posedge clk_b);
        wd_hit = 1'b1;
      end
    join_any
    disable fork;
    if (wd_hit) begin
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule